// File: doc/BRIEF.md
# Relocatable Quad Overlay Window

This block keeps four data registers that shadow a four-entry window inside a register address space of 512 words. Reads and single-word writes whose address lands inside the window reach the overlay registers. Every other address reaches an ordinary backing array, which is held inside the block. A move command gives the window a new base address. An optional flag on that command zeroes all four overlay registers at the moment of the move. A wide load port fills all four overlay registers in a single cycle from one 128-bit word.

A zeroed overlay word acts as a no-operation when fetched. A fetch loop that runs out of the overlay therefore executes nothing stale on its first pass if the move cleared the overlay. If the window is moved into the top eight words of the space, the overlay is hidden: those words then reach the backing array, and the overlay keeps its contents out of sight until the window is moved back down.

Top module: `quad_overlay`

## Requirements
- R1: After reset the window base is 0x1F4, the window is visible (`winHidden` = 0), and all four overlay words read as zero.
- R2: The window base is always a multiple of four. The two low bits of `setBase` are ignored, and `winBase` reports the aligned base.
- R3: A read whose address bits [8:2] match the visible base returns overlay word number `rdAddr[1:0]`. Any other read returns the backing array word at `rdAddr`.
- R4: A write that hits the visible window changes only the addressed overlay word. The backing word at that address is untouched and can be read again once the window has moved away.
- R5: A move with `setClear` = 1 zeroes all four overlay words at the same clock edge. A move with `setClear` = 0 keeps their contents, which then appear at the new base.
- R6: A quad load puts bits [31:0] of `quadData` in the word at the base, [63:32] in base+1, [95:64] in base+2 and [127:96] in base+3.
- R7: When a quad load and a move with clear fall in the same cycle, the clear wins and the overlay reads as zero afterwards.
- R8: A move to any base from 0x1F8 to 0x1FF hides the overlay (`winHidden` = 1). Reads and writes in that range then reach the backing array. A move to any lower base makes the overlay visible again.
- R9: Reads are combinational and decode against the base held before any move issued in the same cycle. The new base takes effect at the next clock edge.
- R10: When a quad load and a single write to an overlay word fall in the same cycle, the quad load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setWin | input | 1 | Move the window this cycle |
| setBase | input | 9 | New base address (low two bits ignored) |
| setClear | input | 1 | Zero the overlay along with the move |
| quadLoad | input | 1 | Load all four overlay words this cycle |
| quadData | input | 128 | Wide word for the quad load, word 0 in bits [31:0] |
| rdAddr | input | 9 | Read address |
| rdData | output | 32 | Combinational read data |
| wrEn | input | 1 | Single-word write enable |
| wrAddr | input | 9 | Write address |
| wrData | input | 32 | Write data |
| winHidden | output | 1 | Overlay currently hidden |
| winBase | output | 9 | Current aligned window base |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 9-bit address and a reset base of 0x1F4. With these values the reset window sits just below the hiding zone, so one move reaches the hidden range at 0x1F8 to 0x1FF and another brings the window back down. The bench covers both the kept and the cleared overlay contents. It also covers the two same-cycle collisions: quad load against a clearing move, and quad load against a single-word write.

// File: rtl/qov_pkg.sv
package qov_pkg;
  localparam int QOV_LANES  = 4;
  localparam int QOV_LANE_W = $clog2(QOV_LANES);

  typedef struct packed {
    logic                  clearAll;
    logic                  loadQuad;
    logic [QOV_LANES-1:0]  wrLane;
    logic                  wrBacking;
    logic                  rdHit;
    logic [QOV_LANE_W-1:0] rdLane;
  } qovStrobes_t;
endpackage

// File: rtl/qov_control.sv
module qov_control
  import qov_pkg::*;
#(
  parameter int              ADDR_W     = 9,
  parameter logic [ADDR_W-1:0] RESET_BASE = 9'h1F4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setWin,
  input  logic [ADDR_W-1:0] setBase,
  input  logic              setClear,
  input  logic              quadLoad,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output qovStrobes_t       strobes,
  output logic              winHidden,
  output logic [ADDR_W-1:0] winBase
);
  localparam int LW = QOV_LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(QOV_LANES - 1);
  localparam logic [ADDR_W-1:0] HIDE_START = ADDR_W'(DEPTH - 2 * QOV_LANES);

  logic [ADDR_W-1:0] baseR;
  logic hidden;
  logic wrHit;
  logic ovlWrite;

  always_ff @(posedge clk) begin
    if (!rstN) baseR <= RESET_BASE & ~LANE_MASK;
    else if (setWin) baseR <= setBase & ~LANE_MASK;
  end

  assign hidden = (baseR >= HIDE_START);
  assign wrHit  = wrEn && !hidden && (wrAddr[ADDR_W-1:LW] == baseR[ADDR_W-1:LW]);

  always_comb begin
    strobes.clearAll  = setWin && setClear;
    strobes.loadQuad  = quadLoad && !strobes.clearAll;
    ovlWrite          = wrHit && !strobes.clearAll && !quadLoad;
    for (int i = 0; i < QOV_LANES; i++)
      strobes.wrLane[i] = ovlWrite && (wrAddr[LW-1:0] == LW'(i));
    strobes.wrBacking = wrEn && !wrHit;
    strobes.rdHit     = !hidden && (rdAddr[ADDR_W-1:LW] == baseR[ADDR_W-1:LW]);
    strobes.rdLane    = rdAddr[LW-1:0];
  end

  assign winHidden = hidden;
  assign winBase   = baseR;
endmodule

// File: rtl/qov_datapath.sv
module qov_datapath
  import qov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  qovStrobes_t                 strobes,
  input  logic [QOV_LANES*DATA_W-1:0] quadData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ovlReg [QOV_LANES];
  logic [DATA_W-1:0] backMem [DEPTH];

  for (genvar g = 0; g < QOV_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)                  ovlReg[g] <= '0;
      else if (strobes.clearAll)  ovlReg[g] <= '0;
      else if (strobes.loadQuad)  ovlReg[g] <= quadData[g*DATA_W +: DATA_W];
      else if (strobes.wrLane[g]) ovlReg[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrBacking) backMem[wrAddr] <= wrData;
  end

  assign rdData = strobes.rdHit ? ovlReg[strobes.rdLane] : backMem[rdAddr];
endmodule

// File: rtl/quad_overlay.sv
module quad_overlay
  import qov_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 9,
  parameter logic [ADDR_W-1:0] RESET_BASE = 9'h1F4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        setWin,
  input  logic [ADDR_W-1:0]           setBase,
  input  logic                        setClear,
  input  logic                        quadLoad,
  input  logic [QOV_LANES*DATA_W-1:0] quadData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        winHidden,
  output logic [ADDR_W-1:0]           winBase
);
  qovStrobes_t strobes;

  qov_control #(.ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE)) ctl (
    .clk(clk), .rstN(rstN), .setWin(setWin), .setBase(setBase),
    .setClear(setClear), .quadLoad(quadLoad), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes),
    .winHidden(winHidden), .winBase(winBase)
  );

  qov_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .quadData(quadData),
    .rdAddr(rdAddr), .rdData(rdData), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/quad_overlay_chk.sv
module quad_overlay_chk
  import qov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        setWin,
  input logic [ADDR_W-1:0]           setBase,
  input logic                        setClear,
  input logic                        quadLoad,
  input logic [QOV_LANES*DATA_W-1:0] quadData,
  input logic [ADDR_W-1:0]           rdAddr,
  input logic [DATA_W-1:0]           rdData,
  input logic                        winHidden,
  input logic [ADDR_W-1:0]           winBase
);
  localparam int LW = QOV_LANE_W;
  localparam logic [ADDR_W-1:0] HIDE_START = ADDR_W'((1 << ADDR_W) - 2 * QOV_LANES);

  logic rdInWin;
  assign rdInWin = !winHidden && (rdAddr[ADDR_W-1:LW] == winBase[ADDR_W-1:LW]);

  // R2
  base_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWin |=> winBase == {$past(setBase[ADDR_W-1:LW]), LW'(0)});

  // R8
  hidden_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setWin && setBase >= HIDE_START) |=> winHidden);

  // R8
  visible_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setWin && setBase < HIDE_START) |=> !winHidden);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setWin && setClear) |=> (!rdInWin || rdData == '0));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setWin && setClear && quadLoad) |=> (!rdInWin || rdData == '0));

  // R6
  quad_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quadLoad && !setWin) |=>
      (!rdInWin || rdData == DATA_W'($past(quadData) >> (rdAddr[LW-1:0] * DATA_W))));
endmodule

bind quad_overlay quad_overlay_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .setWin(setWin), .setBase(setBase),
  .setClear(setClear), .quadLoad(quadLoad), .quadData(quadData),
  .rdAddr(rdAddr), .rdData(rdData), .winHidden(winHidden), .winBase(winBase)
);

// File: tb/quad_overlay_test.sv
module quad_overlay_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         setWin = 1'b0;
  logic [8:0]   setBase = '0;
  logic         setClear = 1'b0;
  logic         quadLoad = 1'b0;
  logic [127:0] quadData = '0;
  logic [8:0]   rdAddr = '0;
  logic [31:0]  rdData;
  logic         wrEn = 1'b0;
  logic [8:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic         winHidden;
  logic [8:0]   winBase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  localparam logic [127:0] Q1 = {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000};
  localparam logic [127:0] Q2 = {32'hE000_0003, 32'hE000_0002, 32'hE000_0001, 32'hE000_0000};

  quad_overlay uut (
    .clk(clk), .rstN(rstN), .setWin(setWin), .setBase(setBase),
    .setClear(setClear), .quadLoad(quadLoad), .quadData(quadData),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .winHidden(winHidden), .winBase(winBase)
  );

  always #10 clk = ~clk;

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = rdData;
          1: act = 32'(winBase);
          default: act = 32'(winHidden);
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic pushRd(input logic [8:0] a, input logic [31:0] e, input string tag);
    rdAddr = a;
    sb.push_back('{0, e, tag});
  endtask

  task automatic expectRd(input logic [8:0] a, input logic [31:0] e, input string tag);
    pushRd(a, e, tag);
    @(negedge clk);
  endtask

  task automatic expectStatus(input logic [8:0] b, input logic h, input string tag);
    sb.push_back('{1, 32'(b), tag});
    sb.push_back('{2, 32'(h), tag});
    @(negedge clk);
  endtask

  task automatic cmd(input logic sw, input logic [8:0] b, input logic clr,
                     input logic ql, input logic [127:0] qd,
                     input logic we, input logic [8:0] wa, input logic [31:0] wd);
    setWin = sw; setBase = b; setClear = clr;
    quadLoad = ql; quadData = qd;
    wrEn = we; wrAddr = wa; wrData = wd;
    @(negedge clk);
    setWin = 1'b0; setClear = 1'b0; quadLoad = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    cmd(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, a, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    expectStatus(9'h1F4, 1'b0, "R1 reset base");
    expectRd(9'h1F4, 32'h0, "R1 reset overlay word0");
    expectRd(9'h1F7, 32'h0, "R1 reset overlay word3");

    for (int i = 0; i < 4; i++) wr(9'h010 + 9'(i), 32'hA000_0000 + i);
    wr(9'h1FC, 32'hB000_01FC);

    cmd(1'b0, '0, 1'b0, 1'b1, Q1, 1'b0, '0, '0);
    expectRd(9'h1F4, 32'hD000_0000, "R6 quad word0 at base");
    expectRd(9'h1F7, 32'hD000_0003, "R6 quad word3 at base+3");

    wr(9'h1F5, 32'hEEEE_0001);
    expectRd(9'h1F5, 32'hEEEE_0001, "R4 write hits overlay");
    expectRd(9'h010, 32'hA000_0000, "R3 outside window reads backing");

    // R9: read in the move cycle still decodes the old base
    pushRd(9'h1F6, 32'hD000_0002, "R9 old base during move");
    cmd(1'b1, 9'h011, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    expectStatus(9'h010, 1'b0, "R2 aligned base after move");
    expectRd(9'h010, 32'hD000_0000, "R5 contents kept word0");
    expectRd(9'h011, 32'hEEEE_0001, "R5 contents kept word1");

    wr(9'h012, 32'hF00D_0012);
    expectRd(9'h012, 32'hF00D_0012, "R4 overlay write at new base");

    cmd(1'b1, 9'h1FE, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    expectStatus(9'h1FC, 1'b1, "R8 hidden after move to top");
    expectRd(9'h1FC, 32'hB000_01FC, "R8 hidden range reads backing");
    expectRd(9'h012, 32'hA000_0002, "R4 backing untouched by overlay write");
    expectRd(9'h010, 32'hA000_0000, "R3 backing after window left");
    wr(9'h1FD, 32'h1234_5678);
    expectRd(9'h1FD, 32'h1234_5678, "R8 hidden range write reaches backing");

    cmd(1'b1, 9'h010, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    expectStatus(9'h010, 1'b0, "R8 visible again");
    expectRd(9'h012, 32'hF00D_0012, "R5 contents kept through hiding");

    cmd(1'b1, 9'h020, 1'b1, 1'b0, '0, 1'b0, '0, '0);
    for (int i = 0; i < 4; i++) expectRd(9'h020 + 9'(i), 32'h0, "R5 clear on move");

    cmd(1'b0, '0, 1'b0, 1'b1, Q2, 1'b0, '0, '0);
    expectRd(9'h021, 32'hE000_0001, "R6 quad word1");

    cmd(1'b1, 9'h020, 1'b1, 1'b1, Q1, 1'b0, '0, '0);
    expectRd(9'h020, 32'h0, "R7 clear beats quad load word0");
    expectRd(9'h023, 32'h0, "R7 clear beats quad load word3");

    cmd(1'b0, '0, 1'b0, 1'b1, Q2, 1'b1, 9'h022, 32'h0000_0BAD);
    expectRd(9'h022, 32'hE000_0002, "R10 quad load beats single write");
    expectRd(9'h020, 32'hE000_0000, "R10 quad word0 intact");

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule